// File: doc/BRIEF.md
# Serial Port Interrupt Status Bank

This block collects four event sources of a serial port into one set of interrupt registers on a 32-bit, word-addressed register bus. A one-cycle pulse on an event input latches the matching status bit, and the bit stays latched until software clears it. Software clears status bits by writing ones to the status word. For testing, software can also force status bits high through a write-only test word. A mask word selects which latched events reach the outputs.

Each source has its own level interrupt line, so an interrupt controller can route the four sources apart. A line is high while its status bit and its mask bit are both set. The bus is a plain strobe interface: a write takes effect at the clock edge where the write strobe is high, and a read returns data combinationally while the read strobe is high.

Top module: `serial_irq_bank`

## Requirements
- R1: Reset, active low, clears the status and enable words, so every interrupt line is low and both words read back as zero.
- R2: The status bits are sticky. Bit 0 is TX watermark, bit 1 is RX watermark, bit 2 is TX empty and bit 3 is RX overflow. A high `hw_event[i]` at a clock edge sets status bit i. A bit holds its value when it sees no event and no write.
- R3: A write to byte offset 0x00 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A write to byte offset 0x08 ORs data bits [3:0] into the status word.
- R5: A write to byte offset 0x04 loads the enable word from data bits [3:0]. The enable word reads back at 0x04 with bits [31:4] zero. The status word reads at 0x00 with bits [31:4] zero.
- R6: `irq_out[i]` is high exactly when status bit i and enable bit i are both set. It follows any change of either bit from the clock edge that makes the change.
- R7: Reads of offset 0x08 return zero.
- R8: When an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R9: Writes to any other offset, including addresses whose bits [1:0] are not zero, change nothing. Reads of those addresses return zero.
- R10: `bus_rdata` is zero while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| hw_event | input | 4 | Event pulses from the serial port, one per source |
| irq_out | output | 4 | Level interrupt lines, one per source |

## Verification
The assertions check on every cycle the following: an event leaves its bit set on the next cycle even when a clear hits the same bit; a clearing write removes exactly the written bits that saw no event; a test write leaves the written bits set; the status and enable words hold when nothing touches them; no interrupt line is high without its enable bit; and test-word reads return zero. The bench sweeps every status and enable pattern pair to show the exact output values. It sweeps status against clear masks and every event mask against a full clear. It also shows the mapping of each source to its bit, the masking of the upper data bits, and that the unmapped and misaligned addresses change nothing.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;

    // Word index of each register (byte offset / 4)
    localparam int unsigned WORD_STATUS = 0;
    localparam int unsigned WORD_ENABLE = 1;
    localparam int unsigned WORD_TEST   = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_TEST
    } reg_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import serial_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            if (widx == WIDX_W'(WORD_STATUS))      sel = SEL_STATUS;
            else if (widx == WIDX_W'(WORD_ENABLE)) sel = SEL_ENABLE;
            else if (widx == WIDX_W'(WORD_TEST))   sel = SEL_TEST;
        end
    end
endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic en_load,
    input  logic en_value,
    output logic status_q,
    output logic enable_q,
    output logic irq
);
    logic status_d;

    // Any set beats a clear in the same cycle
    always_comb begin
        status_d = status_q;
        if (hw_set || sw_set) status_d = 1'b1;
        else if (sw_clr)      status_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            enable_q <= 1'b0;
        end else begin
            status_q <= status_d;
            if (en_load) enable_q <= en_value;
        end
    end

    assign irq = status_q & enable_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import serial_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                rd_en,
    input  reg_sel_e            sel,
    input  logic [NUM_SRC-1:0]  status,
    input  logic [NUM_SRC-1:0]  enable,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STATUS: rdata[NUM_SRC-1:0] = status;
                SEL_ENABLE: rdata[NUM_SRC-1:0] = enable;
                SEL_TEST,
                SEL_NONE:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/serial_irq_bank.sv
module serial_irq_bank
    import serial_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] hw_event,
    output logic [NUM_SRC-1:0] irq_out
);
    reg_sel_e           sel;
    logic               wr_status;
    logic               wr_enable;
    logic               wr_test;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic               unused_wdata_hi;

    irq_reg_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_status = bus_wr && (sel == SEL_STATUS);
    assign wr_enable = bus_wr && (sel == SEL_ENABLE);
    assign wr_test   = bus_wr && (sel == SEL_TEST);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_status_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_set   (hw_event[g]),
            .sw_set   (wr_test & bus_wdata[g]),
            .sw_clr   (wr_status & bus_wdata[g]),
            .en_load  (wr_enable),
            .en_value (bus_wdata[g]),
            .status_q (status_q[g]),
            .enable_q (enable_q[g]),
            .irq      (irq_out[g])
        );
    end

    irq_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_rmux (
        .rd_en  (bus_rd),
        .sel    (sel),
        .status (status_q),
        .enable (enable_q),
        .rdata  (bus_rdata)
    );

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
endmodule

// File: rtl/serial_irq_bank_chk.sv
module serial_irq_bank_chk
    import serial_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] hw_event,
    input logic [NUM_SRC-1:0] irq_out,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(WORD_STATUS * 4);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(WORD_ENABLE * 4);
    localparam logic [ADDR_W-1:0] A_TEST   = ADDR_W'(WORD_TEST * 4);

    // R1: the cycle after a reset edge shows no interrupt
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));

    // R2, R8: an event leaves its bit set, clear or not
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_event != '0) |=> ((status_q & $past(hw_event)) == $past(hw_event)));

    // R2: nothing touching the status word keeps it stable
    p_status_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && hw_event == '0) |=> $stable(status_q));

    // R3: written ones without a competing event are cleared
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STATUS) |=>
        ((status_q & $past(bus_wdata[NUM_SRC-1:0]) & ~$past(hw_event)) == '0));

    // R4: test write sets every written bit
    p_test_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TEST) |=>
        ((status_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    // R5: enable only changes on a write to its word
    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_ENABLE) |=> $stable(enable_q));

    // R6: a line is never high without its enable bit
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~enable_q) == '0));

    // R7: reads of the test word return zero
    p_test_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_TEST) |-> (bus_rdata == '0));

    // R10: no read strobe, no data
    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind serial_irq_bank serial_irq_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_event  (hw_event),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .enable_q  (enable_q)
);

// File: tb/test_serial_irq_bank.sv
module test_serial_irq_bank;
    localparam int N  = 4;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_STAT = 8'h00;
    localparam logic [AW-1:0] A_EN   = 8'h04;
    localparam logic [AW-1:0] A_TEST = 8'h08;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  hw_event = '0;
    logic [N-1:0]  irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    serial_irq_bank #(.NUM_SRC(N), .DATA_W(DW), .ADDR_W(AW)) i_serial_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_event(hw_event), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [N-1:0] ev);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; hw_event = ev;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; hw_event = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic pulse_event(input logic [N-1:0] ev);
        @(negedge clk);
        hw_event = ev;
        @(negedge clk);
        hw_event = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        string src_name [N];
        src_name[0] = "tx watermark";
        src_name[1] = "rx watermark";
        src_name[2] = "tx empty";
        src_name[3] = "rx overflow";

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        #1 check("R1 irq after reset", 32'(irq_out), 32'h0);
        bus_read(A_STAT, rd); check("R1 status after reset", rd, 32'h0);
        bus_read(A_EN, rd);   check("R1 enable after reset", rd, 32'h0);

        // R10: read strobe low
        @(negedge clk); bus_addr = A_EN; #2 check("R10 rdata idle", bus_rdata, 32'h0);
        bus_addr = '0;

        // R2: each source sets its own bit
        for (int b = 0; b < N; b++) begin
            bus_write(A_STAT, 32'hF, '0);
            pulse_event(N'(1 << b));
            bus_read(A_STAT, rd);
            check($sformatf("R2 %s sets bit %0d", src_name[b], b), rd, 32'(1 << b));
            repeat (3) @(negedge clk);
            bus_read(A_STAT, rd);
            check("R2 sticky hold", rd, 32'(1 << b));
        end

        // R4, R5, R6: every status/enable pair
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                bus_write(A_STAT, 32'hF, '0);
                bus_write(A_TEST, 32'(s), '0);
                bus_write(A_EN, 32'(e), '0);
                #1 check("R6 irq equals status and enable", 32'(irq_out), 32'(s & e));
                bus_read(A_STAT, rd); check("R4 test ORs into status", rd, 32'(s));
                bus_read(A_EN, rd);   check("R5 enable readback", rd, 32'(e));
            end
        end

        // R3, R6: clear sweep with all enables on
        bus_write(A_EN, 32'hF, '0);
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                bus_write(A_STAT, 32'hF, '0);
                bus_write(A_TEST, 32'(s), '0);
                bus_write(A_STAT, 32'(c), '0);
                #1 check("R6 irq after clear", 32'(irq_out), 32'(s & ~c & 4'hF));
                bus_read(A_STAT, rd); check("R3 write-one-to-clear", rd, 32'(s & ~c & 4'hF));
            end
        end

        // R8: event and full clear in one cycle
        for (int m = 0; m < 16; m++) begin
            bus_write(A_TEST, 32'hF, '0);
            bus_write(A_STAT, 32'hF, N'(m));
            bus_read(A_STAT, rd); check("R8 set beats clear", rd, 32'(m));
        end

        // R7: test word reads zero
        for (int v = 1; v < 16; v++) begin
            bus_write(A_TEST, 32'(v), '0);
            bus_read(A_TEST, rd); check("R7 test reads zero", rd, 32'h0);
        end

        // R5: upper bits masked
        bus_write(A_EN, 32'hFFFF_FFFF, '0);
        bus_read(A_EN, rd); check("R5 enable upper bits zero", rd, 32'hF);
        bus_write(A_TEST, 32'hFFFF_FFF0, '0);
        bus_read(A_STAT, rd); check("R5 status upper bits zero", rd, 32'hF);

        // R9: unmapped and misaligned addresses
        bus_write(A_STAT, 32'hF, '0);
        bus_write(A_TEST, 32'h5, '0);
        bus_write(A_EN, 32'hA, '0);
        for (int w = 3; w < 64; w++) begin
            bus_write(AW'(w * 4), 32'hFFFF_FFFF, '0);
            bus_read(AW'(w * 4), rd); check("R9 unmapped read zero", rd, 32'h0);
        end
        for (int a = 1; a < 12; a++) begin
            if ((a % 4) != 0) begin
                bus_write(AW'(a), 32'hFFFF_FFFF, '0);
                bus_read(AW'(a), rd); check("R9 misaligned read zero", rd, 32'h0);
            end
        end
        bus_read(A_STAT, rd); check("R9 status untouched", rd, 32'h5);
        bus_read(A_EN, rd);   check("R9 enable untouched", rd, 32'hA);
        #1 check("R9 irq untouched", 32'(irq_out), 32'h0);

        // R1: reset mid-run
        bus_write(A_EN, 32'hF, '0);
        bus_write(A_TEST, 32'hF, '0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1 irq after second reset", 32'(irq_out), 32'h0);
        bus_read(A_STAT, rd); check("R1 status after second reset", rd, 32'h0);
        bus_read(A_EN, rd);   check("R1 enable after second reset", rd, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule